// File: doc/BRIEF.md
# Chip-Select Address Window Decoder

This block maps a memory-mapped access address onto one of several flash chip selects. Each chip select owns a range register. The register defines a window inside a fixed 256 MB address space, in 1 MB units. For every valid request the block reports which chip select claims the address, whether any window claimed it, and the byte offset inside that chip's window. That offset is the address sent to the flash device.

A small write port loads the range registers and a per-chip addressing-mode register. A request is decoded against the register contents that were in place before the clock edge on which it is sampled. The result appears on the outputs one clock later.

Top module: `cs_window_decoder`

## Requirements
- R1: After reset every range register and every addressing-mode bit is zero. All outputs stay zero while reset is held, and any request that follows with no further writes is reported as a miss.
- R2: The window start is range-register bits [11:4], placed at address bits [27:20].
- R3: Range-register bits [27:20] hold the last megabyte inside the window. The window covers addresses below that field plus one, times 1 MB. The top address of that megabyte is a hit; the address one above it is not.
- R4: A range register whose whole 32-bit value is zero never produces a hit for its chip select, including at address 0.
- R5: When several windows contain the address, the lowest-numbered chip select is chosen. `out_sel` then has exactly that one bit set, and `out_cs` holds its index.
- R6: An address that no window contains raises `out_err`, clears `out_hit`, and drives `out_sel`, `out_cs` and `out_offset` to zero.
- R7: `out_offset` is the address minus the selected window's start. When the chip's addressing-mode bit is 0 (3-byte mode), only the low 24 bits are kept. When the bit is 1 (4-byte mode), the full difference is kept. The mode register is written with `cfg_idx` = NUM_CS (5), and data bit i sets the mode of chip select i.
- R8: The outputs are registered with a latency of one cycle. `out_valid` equals `req_valid` from the previous cycle. While `out_valid` is 0, `out_hit`, `out_err`, `out_sel`, `out_cs` and `out_offset` are all zero.
- R9: A write with `cfg_idx` below NUM_CS loads that chip's range register. A write with `cfg_idx` above NUM_CS (6 or 7) changes nothing. A request presented in the same cycle as a write is decoded with the old contents.
- R10: Windows placed back to back hand over exactly at the boundary. The first address of a window goes to that window's chip select with offset 0, and the address just below it goes to the previous chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Target: 0..4 range registers, 5 addressing-mode register |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request address is valid |
| req_addr | input | 28 | Request address inside the 256 MB space |
| out_valid | output | 1 | Registered request-valid |
| out_hit | output | 1 | Address fell inside an enabled window |
| out_err | output | 1 | Valid address fell inside no window |
| out_cs | output | 3 | Index of the selected chip select |
| out_sel | output | 5 | One-hot chip-select vector |
| out_offset | output | 32 | Flash address inside the selected window |

## Verification
The bench probes both ends of every window: the top address of the last included megabyte and the address one above it. A design that treats the end field as exclusive loses 1 MB per window, or leaks the window into its neighbour.

Zero-valued registers are checked at address 0, which a careless compare of start 0 would claim. Overlapping windows are checked so that a priority encoder facing the wrong way shows up as the higher index. A 32 MB window is read in both addressing modes, so that a missing 24-bit truncation, or a truncation applied in 4-byte mode, changes the offset.

Writes to unused indices, and requests that coincide with a write, show whether the decoder ever sees a half-updated or stray register.

// File: rtl/cs_window_decoder.sv
module cs_window_decoder #(
  parameter int NUM_CS = 5,
  parameter int ADDR_W = 28,
  parameter int MB_LSB = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(NUM_CS+1)-1:0] cfg_idx,
  input  logic [31:0]               cfg_wdata,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_addr,
  output logic                      out_valid,
  output logic                      out_hit,
  output logic                      out_err,
  output logic [$clog2(NUM_CS)-1:0] out_cs,
  output logic [NUM_CS-1:0]         out_sel,
  output logic [31:0]               out_offset
);
  localparam int IDX_W   = $clog2(NUM_CS + 1);
  localparam int CS_W    = $clog2(NUM_CS);
  localparam int FIELD_W = ADDR_W - MB_LSB;
  localparam int NARROW  = 24;

  logic [FIELD_W-1:0] st_f [NUM_CS];
  logic [FIELD_W-1:0] last_f [NUM_CS];
  logic [NUM_CS-1:0]  en_q;
  logic [NUM_CS-1:0]  wide_q;
  logic [ADDR_W-1:0]  win_start [NUM_CS];
  logic [NUM_CS-1:0]  hit_vec;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_win
    logic [ADDR_W:0] lim;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_f[i]   <= '0;
        last_f[i] <= '0;
        en_q[i]   <= 1'b0;
      end else if (cfg_we && cfg_idx == IDX_W'(i)) begin
        st_f[i]   <= cfg_wdata[4 +: FIELD_W];
        last_f[i] <= cfg_wdata[MB_LSB +: FIELD_W];
        en_q[i]   <= |cfg_wdata;
      end
    end
    assign win_start[i] = {st_f[i], {MB_LSB{1'b0}}};
    assign lim          = {1'b0, last_f[i], {MB_LSB{1'b0}}} + (ADDR_W+1)'(1 << MB_LSB);
    assign hit_vec[i]   = en_q[i] && (req_addr >= win_start[i]) && ({1'b0, req_addr} < lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      wide_q <= '0;
    else if (cfg_we && cfg_idx == IDX_W'(NUM_CS))
      wide_q <= cfg_wdata[NUM_CS-1:0];
  end

  logic [CS_W-1:0]   sel_idx;
  logic [ADDR_W-1:0] sel_start;
  logic              sel_wide;
  always_comb begin
    sel_idx   = '0;
    sel_start = '0;
    sel_wide  = 1'b0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        sel_idx   = CS_W'(i);
        sel_start = win_start[i];
        sel_wide  = wide_q[i];
      end
    end
  end

  wire              found  = |hit_vec;
  wire              take   = req_valid && found;
  wire [NUM_CS-1:0] onehot = hit_vec & (~hit_vec + NUM_CS'(1));
  wire [ADDR_W-1:0] diff   = req_addr - sel_start;
  wire [31:0]       off    = sel_wide ? 32'(diff) : 32'(diff[NARROW-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_hit    <= 1'b0;
      out_err    <= 1'b0;
      out_cs     <= '0;
      out_sel    <= '0;
      out_offset <= '0;
    end else begin
      out_valid  <= req_valid;
      out_hit    <= take;
      out_err    <= req_valid && !found;
      out_cs     <= take ? sel_idx : '0;
      out_sel    <= take ? onehot : '0;
      out_offset <= take ? off : '0;
    end
  end
endmodule

module cs_window_decoder_chk #(
  parameter int NUM_CS = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      out_valid,
  input logic                      out_hit,
  input logic                      out_err,
  input logic [$clog2(NUM_CS)-1:0] out_cs,
  input logic [NUM_CS-1:0]         out_sel,
  input logic [31:0]               out_offset,
  input logic [NUM_CS-1:0]         wide_q
);
  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_hit && !out_err && out_sel == '0 && out_offset == '0));
  // R6
  hit_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hit != out_err));
  // R6
  miss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_sel == '0 && out_cs == '0 && out_offset == '0));
  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_sel));
  // R5
  sel_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> ($countones(out_sel) == 1 && out_sel[out_cs]));
  // R7
  narrow_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_hit && !wide_q[out_cs]) |-> (out_offset[31:24] == 8'h00));
endmodule

bind cs_window_decoder cs_window_decoder_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .out_valid(out_valid),
  .out_hit(out_hit), .out_err(out_err), .out_cs(out_cs), .out_sel(out_sel),
  .out_offset(out_offset), .wide_q(wide_q)
);

// File: tb/tb_cs_window_decoder.sv
module tb_cs_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [27:0] req_addr = '0;
  logic        out_valid, out_hit, out_err;
  logic [2:0]  out_cs;
  logic [4:0]  out_sel;
  logic [31:0] out_offset;

  cs_window_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .out_valid(out_valid), .out_hit(out_hit), .out_err(out_err),
    .out_cs(out_cs), .out_sel(out_sel), .out_offset(out_offset)
  );

  always #10 clk = ~clk;

  int unsigned n_cmp = 0, n_bad = 0, cycles = 0;
  string       cur_req = "R1";
  bit          done = 0;

  int unsigned mreg [5];
  bit [4:0]    mwide;
  bit          e_valid, e_hit, e_err;
  int unsigned e_cs, e_sel, e_off;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mreg[i]) mreg[i] = 0;
      mwide = '0;
      {e_valid, e_hit, e_err} = '0;
      e_cs = 0; e_sel = 0; e_off = 0;
    end else begin
      bit found;
      longint a, st, lim;
      found = 0;
      e_valid = req_valid; e_hit = 0; e_err = 0; e_cs = 0; e_sel = 0; e_off = 0;
      if (req_valid) begin
        a = longint'(req_addr);
        for (int c = 0; c < 5; c++) begin
          if (!found && mreg[c] != 0) begin
            st  = longint'((mreg[c] >> 4) & 8'hFF) * 64'h100000;
            lim = (longint'((mreg[c] >> 20) & 8'hFF) + 1) * 64'h100000;
            if (a >= st && a < lim) begin
              found = 1; e_cs = c; e_sel = 1 << c;
              e_off = mwide[c] ? int'(a - st) : int'((a - st) % 64'h1000000);
            end
          end
        end
        e_hit = found; e_err = !found;
      end
      if (cfg_we) begin
        if (cfg_idx < 5) mreg[cfg_idx] = cfg_wdata;
        else if (cfg_idx == 5) mwide = cfg_wdata[4:0];
      end
    end
    #5;
    if (!done) begin
      n_cmp++;
      if (out_valid !== e_valid || out_hit !== e_hit || out_err !== e_err ||
          out_cs !== 3'(e_cs) || out_sel !== 5'(e_sel) || out_offset !== e_off) begin
        n_bad++;
        $display("FAIL %s: got v=%0b h=%0b e=%0b cs=%0d sel=%b off=%h exp v=%0b h=%0b e=%0b cs=%0d sel=%b off=%h",
          cur_req, out_valid, out_hit, out_err, out_cs, out_sel, out_offset,
          e_valid, e_hit, e_err, e_cs, 5'(e_sel), e_off);
      end
    end
  end

  task automatic drive(input bit we, input int idx, input int unsigned d,
                       input bit v, input int unsigned a);
    cfg_we = we; cfg_idx = 3'(idx); cfg_wdata = d;
    req_valid = v; req_addr = 28'(a);
    @(negedge clk);
  endtask

  task automatic wr(input int idx, input int unsigned d);
    drive(1, idx, d, 0, 0);
  endtask

  task automatic rd(input int unsigned a);
    drive(0, 0, 0, 1, a);
  endtask

  function automatic int unsigned mkreg(input int smb, input int emb_excl);
    return ((emb_excl - 1) << 20) | (smb << 4);
  endfunction

  localparam int unsigned MB = 32'h100000;

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R1: empty configuration misses everywhere
    cur_req = "R1";
    rd(0); rd(5 * MB); drive(0, 0, 0, 0, 0);
    // R2 R3 R10: back-to-back windows 0-2, 2-6, 8-16 MB
    cur_req = "R2";
    wr(0, mkreg(0, 2)); wr(1, mkreg(2, 6)); wr(2, mkreg(8, 16));
    rd(0); rd(2 * MB + 5); rd(8 * MB); rd(12 * MB + 32'h1234);
    cur_req = "R3";
    rd(6 * MB - 1); rd(6 * MB); rd(16 * MB - 1); rd(16 * MB); rd(7 * MB);
    cur_req = "R10";
    rd(2 * MB - 1); rd(2 * MB);
    // R8: idle cycles between requests
    cur_req = "R8";
    drive(0, 0, 0, 0, 3 * MB); rd(3 * MB); drive(0, 0, 0, 0, 0); drive(0, 0, 0, 0, 0);
    // R5: overlap, cs3 covers 0-16 MB
    cur_req = "R5";
    wr(3, mkreg(0, 16));
    rd(3 * MB); rd(7 * MB); rd(1 * MB);
    // R4: zero register never hits, even at address 0
    cur_req = "R4";
    wr(0, 0); wr(3, 0);
    rd(0); rd(1 * MB);
    // R6: misses
    cur_req = "R6";
    rd(100 * MB); rd(28'hFFFFFFF);
    // R7: 32 MB window at 32 MB, offset above 16 MB
    cur_req = "R7";
    wr(4, mkreg(32, 64));
    rd(52 * MB + 32'h77); rd(63 * MB + 32'hABCDE);
    wr(5, 32'h10);
    rd(52 * MB + 32'h77); rd(63 * MB + 32'hABCDE);
    wr(5, 32'h00);
    rd(52 * MB + 32'h77);
    // R9: unused indices ignored, same-cycle write uses old contents
    cur_req = "R9";
    wr(6, 32'hFFFFFFFF); wr(7, mkreg(0, 256));
    rd(200 * MB); rd(0); rd(52 * MB);
    drive(1, 0, mkreg(0, 4), 1, 1 * MB);
    rd(1 * MB);
    drive(1, 5, 32'h1F, 1, 52 * MB);
    rd(52 * MB);
    // R5 R7 R10: random configurations and addresses
    cur_req = "R5";
    for (int k = 0; k < 40; k++) begin
      for (int c = 0; c < 5; c++) begin
        int s, e;
        s = int'($urandom_range(0, 200));
        e = s + int'($urandom_range(2, 55));
        wr(c, ($urandom_range(0, 5) == 0) ? 0 : mkreg(s, e));
      end
      wr(5, $urandom);
      for (int j = 0; j < 20; j++) begin
        if ($urandom_range(0, 3) == 0) drive(0, 0, 0, 0, $urandom);
        else rd($urandom_range(0, 260 * MB) & 32'h0FFFFFFF);
      end
    end
    drive(0, 0, 0, 0, 0);
    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles exp completion", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule